// File: doc/BRIEF.md
# Low Battery Dropout Limit Controller

This block keeps the primary backlight bank out of dropout when the supply sags. While protection is armed and the low-battery indication is present, it lowers a brightness ceiling one code at a time, at a pace set by a programmable interval. The bank brightness that leaves the block is the smaller of the programmed level and that ceiling, so the backlight dims slowly instead of flickering or losing current matching.

Once the ceiling has started to fall, it stays down until one of three events clears it. The first is a write of zero to the protection-enable bit. The second is a report that any sink of the bank is floating, which also disarms protection. The third is a control-register write that turns on the bank and sets the disable bit, the enable bit or both. Each of these drops the active flag and returns the ceiling to full scale. Voltage sensing, the detection of floating sinks and the analog current sinks are outside this block.

An internal two-stage synchronizer releases the asynchronous reset, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `dropout_limit_ctrl`

## Requirements
- R1: During reset and after it, `prot_en` and `active` are 0 and `ceiling` holds full scale (all ones, 255 for the default 8-bit width).
- R2: A cycle with `en_wr`=1 loads `en_wdata` into `prot_en`, which shows the new value after the next rising edge.
- R3: While `prot_en`=1 and no clear event is present, a run counter counts consecutive `low_batt` cycles. On the cycle the count equals `step_interval`, `ceiling` drops by one and the count restarts at zero. When `low_batt` drops, the count restarts. With interval N, the run of low cycles therefore steps on its N+1-th cycle and on every N+1 cycles after that.
- R4: The ceiling saturates at 0. Further steps keep it at 0 and keep `active` at 1.
- R5: `active` rises with the first step. Without a clear event, `ceiling` never increases.
- R6: A cycle with `en_wr`=1 and `en_wdata`=0 clears `active` and restores `ceiling` to full scale on the next edge.
- R7: `sink_float`=1 clears `prot_en` and `active` and restores `ceiling` on the next edge, even if the same cycle writes a 1 to the enable bit.
- R8: A cycle with `ctrl_wr`=1, `ctrl_bank`=1 and (`ctrl_dis`,`ctrl_en`) equal to (1,0), (0,1) or (1,1) clears `active` and restores `ceiling`. It leaves `prot_en` unchanged.
- R9: A control write with (`ctrl_dis`,`ctrl_en`)=(0,0), or with `ctrl_bank`=0, leaves `active`, `ceiling` and the step pacing unchanged.
- R10: `level_out` is the smaller of `prog_level` and `ceiling`. It follows a change of `prog_level` in the same cycle.
- R11: While `prot_en`=0, `low_batt` has no effect. `ceiling` stays at full scale and `active` stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the protection-enable bit |
| en_wdata | input | 1 | Value written to the protection-enable bit |
| low_batt | input | 1 | Low-battery indication |
| sink_float | input | 1 | Some sink of the primary bank is floating |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_dis | input | 1 | Disable bit of the control write |
| ctrl_en | input | 1 | Enable bit of the control write |
| ctrl_bank | input | 1 | Primary-bank enable bit of the control write |
| step_interval | input | STEP_W | Extra low-battery cycles between ceiling steps |
| prog_level | input | LVL_W | Programmed bank brightness |
| prot_en | output | 1 | Protection-enable bit state |
| active | output | 1 | Protection has limited the bank |
| ceiling | output | LVL_W | Current brightness ceiling |
| level_out | output | LVL_W | Limited bank brightness |

## Verification
The bench drives the ceiling down to zero at interval 0 and keeps stepping. A design without saturation would wrap to 255 and brighten the bank. It breaks a low-battery run partway through an interval. A counter that is not restarted would step early. It sends control writes with (0,0) and with the bank bit low, which must do nothing, alongside the three restoring combinations. A decoder that is too broad or too narrow would show a wrong ceiling or flag. It also raises a floating sink in the same cycle as a write of 1 to the enable bit, where the wrong priority would leave protection armed.

// File: rtl/dlc_pkg.sv
package dlc_pkg;
  // True when a control write asks the primary bank to resume its setting.
  function automatic logic ctrl_restores(input logic bank, input logic dis, input logic en);
    return bank & (dis | en);
  endfunction
endpackage

// File: rtl/dlc_clear_decode.sv
module dlc_clear_decode
  import dlc_pkg::*;
(
  input  logic prot_en_q,
  input  logic en_wr,
  input  logic en_wdata,
  input  logic sink_float,
  input  logic ctrl_wr,
  input  logic ctrl_dis,
  input  logic ctrl_en,
  input  logic ctrl_bank,
  output logic clr
);
  logic en_zero_wr;
  logic ctrl_hit;

  always_comb begin
    en_zero_wr = en_wr & ~en_wdata;
    ctrl_hit   = ctrl_wr & ctrl_restores(ctrl_bank, ctrl_dis, ctrl_en);
    clr        = sink_float | en_zero_wr | ctrl_hit | ~prot_en_q;
  end
endmodule

// File: rtl/dlc_step_timer.sv
module dlc_step_timer #(
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              low_batt,
  input  logic              clr,
  input  logic [STEP_W-1:0] interval,
  output logic              step
);
  logic [STEP_W-1:0] cnt_q, cnt_d;
  logic              run;

  always_comb begin
    run  = low_batt & ~clr;
    step = run & (cnt_q == interval);
    if (!run || step) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R3
  run_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!low_batt) |=> (cnt_q == '0));
endmodule

// File: rtl/dlc_ceiling.sv
module dlc_ceiling #(
  parameter int LVL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  output logic             active,
  output logic [LVL_W-1:0] ceiling
);
  localparam logic [LVL_W-1:0] FULL = '1;

  logic [LVL_W-1:0] ceil_d;
  logic             act_d;

  always_comb begin
    ceil_d = ceiling;
    act_d  = active;
    if (clr) begin
      ceil_d = FULL;
      act_d  = 1'b0;
    end else if (step) begin
      act_d = 1'b1;
      if (ceiling != '0) ceil_d = ceiling - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceiling <= FULL;
      active  <= 1'b0;
    end else begin
      ceiling <= ceil_d;
      active  <= act_d;
    end
  end

  // R6
  restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ceiling == FULL && !active));
  // R5
  no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> (ceiling <= $past(ceiling)));
  // R3
  step_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && ceiling != '0) |=> (ceiling == $past(ceiling) - 1'b1));
  // R4
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && ceiling == '0) |=> (ceiling == '0 && active));
endmodule

// File: rtl/dropout_limit_ctrl.sv
module dropout_limit_ctrl #(
  parameter int LVL_W  = 8,
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_wr,
  input  logic              en_wdata,
  input  logic              low_batt,
  input  logic              sink_float,
  input  logic              ctrl_wr,
  input  logic              ctrl_dis,
  input  logic              ctrl_en,
  input  logic              ctrl_bank,
  input  logic [STEP_W-1:0] step_interval,
  input  logic [LVL_W-1:0]  prog_level,
  output logic              prot_en,
  output logic              active,
  output logic [LVL_W-1:0]  ceiling,
  output logic [LVL_W-1:0]  level_out
);
  logic rst_meta_q, rst_sync_n;
  logic prot_en_d;
  logic clr, step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    prot_en_d = prot_en;
    if (sink_float) prot_en_d = 1'b0;
    else if (en_wr) prot_en_d = en_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) prot_en <= 1'b0;
    else             prot_en <= prot_en_d;
  end

  dlc_clear_decode u_clr (
    .prot_en_q (prot_en),
    .en_wr     (en_wr),
    .en_wdata  (en_wdata),
    .sink_float(sink_float),
    .ctrl_wr   (ctrl_wr),
    .ctrl_dis  (ctrl_dis),
    .ctrl_en   (ctrl_en),
    .ctrl_bank (ctrl_bank),
    .clr       (clr)
  );

  dlc_step_timer #(.STEP_W(STEP_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .low_batt(low_batt),
    .clr     (clr),
    .interval(step_interval),
    .step    (step)
  );

  dlc_ceiling #(.LVL_W(LVL_W)) u_ceil (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .step   (step),
    .clr    (clr),
    .active (active),
    .ceiling(ceiling)
  );

  always_comb level_out = (prog_level < ceiling) ? prog_level : ceiling;

  // R7
  float_disarm_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sink_float |=> (!prot_en && !active));
  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en_wr && !sink_float) |=> (prot_en == $past(en_wdata)));
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!prot_en && !en_wr) |=> (!active && ceiling == '1));
endmodule

// File: tb/tb_dropout_limit_ctrl.sv
module tb_dropout_limit_ctrl;
  localparam int LVL_W  = 8;
  localparam int STEP_W = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic en_wr, en_wdata, low_batt, sink_float;
  logic ctrl_wr, ctrl_dis, ctrl_en, ctrl_bank;
  logic [STEP_W-1:0] step_interval;
  logic [LVL_W-1:0]  prog_level;
  logic prot_en, active;
  logic [LVL_W-1:0] ceiling, level_out;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  bit m_en, m_act;
  int m_ceil, m_cnt;

  always #2 clk = ~clk;

  dropout_limit_ctrl #(.LVL_W(LVL_W), .STEP_W(STEP_W)) dut (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .low_batt(low_batt), .sink_float(sink_float), .ctrl_wr(ctrl_wr),
    .ctrl_dis(ctrl_dis), .ctrl_en(ctrl_en), .ctrl_bank(ctrl_bank),
    .step_interval(step_interval), .prog_level(prog_level),
    .prot_en(prot_en), .active(active), .ceiling(ceiling), .level_out(level_out)
  );

  function automatic int exp_level(int p, int c);
    return (p < c) ? p : c;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "prot_en", int'(prot_en), int'(m_en));
    chk(req, "active", int'(active), int'(m_act));
    chk(req, "ceiling", int'(ceiling), m_ceil);
    chk(req, "level_out", int'(level_out), exp_level(int'(prog_level), m_ceil));
  endtask

  task automatic model_edge();
    bit clr;
    clr = sink_float | (en_wr & ~en_wdata) |
          (ctrl_wr & ctrl_bank & (ctrl_dis | ctrl_en)) | ~m_en;
    if (clr) begin
      m_ceil = 255; m_act = 0; m_cnt = 0;
    end else if (low_batt) begin
      if (m_cnt == int'(step_interval)) begin
        m_cnt = 0; m_act = 1;
        if (m_ceil > 0) m_ceil = m_ceil - 1;
      end else m_cnt++;
    end else m_cnt = 0;
    if (sink_float) m_en = 0;
    else if (en_wr) m_en = en_wdata;
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_edge();
    #1;
    check_all(req);
    en_wr = 0; ctrl_wr = 0; sink_float = 0;
  endtask

  task automatic ticks(int n, string req);
    for (int i = 0; i < n; i++) tick(req);
  endtask

  task automatic ctrl_write(bit b, bit d, bit e);
    ctrl_wr = 1; ctrl_bank = b; ctrl_dis = d; ctrl_en = e;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h1d5e));
    rst_n = 0; en_wr = 0; en_wdata = 0; low_batt = 0; sink_float = 0;
    ctrl_wr = 0; ctrl_dis = 0; ctrl_en = 0; ctrl_bank = 0;
    step_interval = 2; prog_level = 8'd255;
    m_en = 0; m_act = 0; m_ceil = 255; m_cnt = 0;
    #9;
    check_all("R1");
    @(negedge clk); rst_n = 1;
    ticks(3, "R1");
    // R11: low battery without protection
    low_batt = 1; ticks(5, "R11");
    low_batt = 0;
    // R2: arm protection
    en_wr = 1; en_wdata = 1; tick("R2");
    // R3: interval 2 gives a step every third low cycle
    low_batt = 1; ticks(9, "R3");
    low_batt = 0; tick("R3");
    low_batt = 1; ticks(2, "R3");
    low_batt = 0;
    // R10
    prog_level = 8'd253; #1 check_all("R10");
    prog_level = 8'd100; #1 check_all("R10");
    // R9: non-restoring control writes
    ctrl_write(0, 1, 1); tick("R9");
    ctrl_write(1, 0, 0); tick("R9");
    // R8: each restoring combination
    ctrl_write(1, 1, 0); tick("R8");
    low_batt = 1; ticks(4, "R5");
    ctrl_write(1, 0, 1); tick("R8");
    ticks(4, "R5");
    ctrl_write(1, 1, 1); tick("R8");
    ticks(4, "R5");
    // R6
    en_wr = 1; en_wdata = 0; tick("R6");
    ticks(3, "R11");
    // R4: drive to the floor at interval 0
    en_wr = 1; en_wdata = 1; tick("R2");
    step_interval = 0; ticks(262, "R4");
    // R7: floating sink beats a write of one
    sink_float = 1; en_wr = 1; en_wdata = 1; tick("R7");
    ticks(2, "R7");
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      low_batt = ($urandom_range(0, 9) < 8);
      if (r < 3) begin en_wr = 1; en_wdata = $urandom_range(0, 3) != 0; end
      else if (r < 4) sink_float = 1;
      else if (r < 9) ctrl_write($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      if ($urandom_range(0, 19) == 0) step_interval = STEP_W'($urandom_range(0, 3));
      if ($urandom_range(0, 9) == 0) prog_level = LVL_W'($urandom_range(0, 255));
      tick("R5");
    end
    done = 1;
    summary();
  end
endmodule